// File: doc/BRIEF.md
# Console Serial Register Interface

This block presents two register channels to a processor bus and connects them to a byte-serial console storage link. Bytes arrive from the link on the receive channel. Bytes written by the processor leave on the transmit channel. Each channel has a control/status register, which holds an interrupt-enable bit and a done bit, and an 8-bit data buffer register. Each channel drives its own interrupt request line. Reading and writing the registers has side effects: done is set and cleared, error flags are cleared, and interrupt requests are raised or dropped.

The protocol engine on the far side loads receive bytes with a valid strobe. When a byte arrives before the previous one was read, it is flagged as an overrun. A byte written to the transmit buffer is handed to the engine as a one-cycle strobe, and the transmit channel then reports done again. When software drops the transmit break bit from 1 to 0, the block issues a one-cycle init request to the engine.

Bus accesses take one cycle. `busRdata` always shows the register selected by `busAddr`. The side effects of a read happen only when `busSel` is high and `busWrite` is low, and they take effect at the clock edge that ends the access. Register index: 0 receive CSR, 1 receive buffer, 2 transmit CSR, 3 transmit buffer.

Top module: `consoleRegIf`

## Requirements
- R1: After reset the receive CSR, the receive buffer and both interrupt requests read 0, and the transmit CSR reads 0x0080 (done set).
- R2: The read layout is as follows. In both CSRs, bit 7 is done and bit 6 is enable. The transmit CSR also carries break at bit 0 and maintenance at bit 2. The receive buffer holds the byte in bits 7:0, received break in bit 13, overrun in bit 14 and the summary error in bit 15. The transmit buffer reads 0, and every other bit reads 0.
- R3: Only the enable, break and maintenance bits take bus writes. A CSR write leaves done unchanged.
- R4: Writing a CSR with bit 6 = 0 drops that channel's interrupt request, one edge later, and leaves the other channel's request alone.
- R5: Writing a CSR with bit 6 = 1 raises that channel's request only if done is 1 and enable was 0. Otherwise the request keeps its value.
- R6: A bus read of the receive buffer returns the byte and its flags. At the edge that ends the read, receive done, bits 13 to 15 and the receive request are cleared, and the byte is kept.
- R7: An engine load stores the byte and sets receive done. It raises the receive request when enable is 1.
- R8: A load while receive done is 1, with no buffer read in the same cycle, sets overrun and the error flag.
- R9: A load with the break input high sets received break and the error flag.
- R10: A transmit buffer write keeps only bits 7:0. On the next cycle, done and the transmit request are 0, and `engTxValid` is high for that one cycle carrying the byte. On the cycle after that, done is 1 and the request is 1 if enable is 1.
- R11: A transmit CSR write that changes break from 1 to 0 drives `engInit` high for exactly the next cycle. No other write does so.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus access strobe for this cycle |
| busWrite | input | 1 | 1 = write access, 0 = read access |
| busAddr | input | ADDR_W | Register index |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Contents of the selected register |
| rxIrq | output | 1 | Receive interrupt request |
| txIrq | output | 1 | Transmit interrupt request |
| engRxValid | input | 1 | Engine delivers a receive byte |
| engRxByte | input | BYTE_W | Received byte |
| engRxBreak | input | 1 | Break condition reported with the byte |
| engTxValid | output | 1 | Transmit byte handed to the engine |
| engTxByte | output | BYTE_W | Byte being handed over |
| engInit | output | 1 | One-cycle init request to the engine |

## Verification
The hardest case to reach is a transmit CSR write that sets enable in the one cycle while done is low during a handoff. The enable rule by itself must not raise the request there. The request still rises on the following edge, because the handoff completes with enable already set. The bench reaches this case by writing the transmit buffer and the transmit CSR on two back-to-back edges. A random phase then mixes engine loads with buffer reads and CSR writes on the same edges, which covers the ordering between overrun detection and a buffer read in the same cycle.

// File: rtl/consoleRegPkg.sv
package consoleRegPkg;

  // bit positions that software decodes
  localparam int unsigned IE_BIT    = 6;
  localparam int unsigned DONE_BIT  = 7;
  localparam int unsigned BRK_BIT   = 0;
  localparam int unsigned MAINT_BIT = 2;
  localparam int unsigned RBRK_BIT  = 13;
  localparam int unsigned OVR_BIT   = 14;
  localparam int unsigned ERR_BIT   = 15;
  localparam int unsigned MIN_DATA_W = 16;

  typedef enum logic [1:0] {
    SEL_RX_CSR = 2'd0,
    SEL_RX_BUF = 2'd1,
    SEL_TX_CSR = 2'd2,
    SEL_TX_BUF = 2'd3
  } regSel_e;

  typedef struct packed {
    logic rxCsrWr;
    logic rxBufRd;
    logic txCsrWr;
    logic txBufWr;
    logic txHandDone;
  } ctlStrobes_t;

  // interrupt request after a CSR write, shared by both channels
  function automatic logic irqAfterCsrWrite(logic oldIrq, logic oldDone,
                                            logic oldIe, logic newIe);
    if (!newIe)
      return 1'b0;
    else if (oldDone && !oldIe)
      return 1'b1;
    else
      return oldIrq;
  endfunction

endpackage

// File: rtl/consoleRegCtl.sv
module consoleRegCtl
  import consoleRegPkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wdataBrk,
  input  logic              txBrkNow,
  output ctlStrobes_t       stb,
  output logic              engTxValid,
  output logic              engInit
);

  logic    upperZero;
  regSel_e sel;
  logic    hit;

  generate
    if (ADDR_W > 2) begin : g_wideAddr
      assign upperZero = ~|busAddr[ADDR_W-1:2];
    end else begin : g_narrowAddr
      assign upperZero = 1'b1;
    end
  endgenerate

  assign sel = regSel_e'(busAddr[1:0]);
  assign hit = busSel && upperZero;

  always_comb begin
    stb            = '0;
    stb.rxCsrWr    = hit && busWrite  && (sel == SEL_RX_CSR);
    stb.rxBufRd    = hit && !busWrite && (sel == SEL_RX_BUF);
    stb.txCsrWr    = hit && busWrite  && (sel == SEL_TX_CSR);
    stb.txBufWr    = hit && busWrite  && (sel == SEL_TX_BUF);
    stb.txHandDone = engTxValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engTxValid <= 1'b0;
      engInit    <= 1'b0;
    end else begin
      engTxValid <= stb.txBufWr;
      engInit    <= stb.txCsrWr && txBrkNow && !wdataBrk;
    end
  end

  // R11: init request only follows a 1 -> 0 transition of break
  a_r11_init_on_break_fall: assert property (@(posedge clk) disable iff (!rstN)
    engInit |-> ($past(txBrkNow) && !txBrkNow));

  // R11: init request never lasts longer than one cycle
  a_r11_init_single: assert property (@(posedge clk) disable iff (!rstN)
    engInit |=> !engInit);

  // R10: handoff strobe is preceded by a bus write
  a_r10_hand_after_write: assert property (@(posedge clk) disable iff (!rstN)
    engTxValid |-> $past(busSel && busWrite));

endmodule

// File: rtl/consoleRegPath.sv
module consoleRegPath
  import consoleRegPkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [1:0]        rdSel,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              engRxValid,
  input  logic [BYTE_W-1:0] engRxByte,
  input  logic              engRxBreak,
  output logic [DATA_W-1:0] busRdata,
  output logic              rxIrq,
  output logic              txIrq,
  output logic [BYTE_W-1:0] txByte,
  output logic              txBrkNow
);

  // receive channel state
  logic              rxIe, rxDone, rxBrk, rxOvr, rxErr;
  logic [BYTE_W-1:0] rxData;
  logic              nRxIe, nRxDone, nRxBrk, nRxOvr, nRxErr, nRxIrq;
  logic [BYTE_W-1:0] nRxData;

  // transmit channel state
  logic              txIe, txDone, txBrk, txMaint;
  logic              nTxIe, nTxDone, nTxBrk, nTxMaint, nTxIrq;
  logic [BYTE_W-1:0] nTxByte;

  assign txBrkNow = txBrk;

  always_comb begin
    nRxIe   = rxIe;
    nRxDone = rxDone;
    nRxBrk  = rxBrk;
    nRxOvr  = rxOvr;
    nRxErr  = rxErr;
    nRxIrq  = rxIrq;
    nRxData = rxData;
    if (stb.rxCsrWr) begin
      nRxIrq = irqAfterCsrWrite(rxIrq, rxDone, rxIe, busWdata[IE_BIT]);
      nRxIe  = busWdata[IE_BIT];
    end
    if (stb.rxBufRd) begin
      nRxDone = 1'b0;
      nRxBrk  = 1'b0;
      nRxOvr  = 1'b0;
      nRxErr  = 1'b0;
      nRxIrq  = 1'b0;
    end
    if (engRxValid) begin
      if (rxDone && !stb.rxBufRd) begin
        nRxOvr = 1'b1;
        nRxErr = 1'b1;
      end
      if (engRxBreak) begin
        nRxBrk = 1'b1;
        nRxErr = 1'b1;
      end
      nRxData = engRxByte;
      nRxDone = 1'b1;
      if (nRxIe) nRxIrq = 1'b1;
    end
  end

  always_comb begin
    nTxIe    = txIe;
    nTxDone  = txDone;
    nTxBrk   = txBrk;
    nTxMaint = txMaint;
    nTxIrq   = txIrq;
    nTxByte  = txByte;
    if (stb.txCsrWr) begin
      nTxIrq   = irqAfterCsrWrite(txIrq, txDone, txIe, busWdata[IE_BIT]);
      nTxIe    = busWdata[IE_BIT];
      nTxBrk   = busWdata[BRK_BIT];
      nTxMaint = busWdata[MAINT_BIT];
    end
    if (stb.txHandDone) begin
      nTxDone = 1'b1;
      if (nTxIe) nTxIrq = 1'b1;
    end
    if (stb.txBufWr) begin
      nTxByte = busWdata[BYTE_W-1:0];
      nTxDone = 1'b0;
      nTxIrq  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxIe    <= 1'b0;
      rxDone  <= 1'b0;
      rxBrk   <= 1'b0;
      rxOvr   <= 1'b0;
      rxErr   <= 1'b0;
      rxIrq   <= 1'b0;
      rxData  <= '0;
      txIe    <= 1'b0;
      txDone  <= 1'b1;
      txBrk   <= 1'b0;
      txMaint <= 1'b0;
      txIrq   <= 1'b0;
      txByte  <= '0;
    end else begin
      rxIe    <= nRxIe;
      rxDone  <= nRxDone;
      rxBrk   <= nRxBrk;
      rxOvr   <= nRxOvr;
      rxErr   <= nRxErr;
      rxIrq   <= nRxIrq;
      rxData  <= nRxData;
      txIe    <= nTxIe;
      txDone  <= nTxDone;
      txBrk   <= nTxBrk;
      txMaint <= nTxMaint;
      txIrq   <= nTxIrq;
      txByte  <= nTxByte;
    end
  end

  always_comb begin
    busRdata = '0;
    case (regSel_e'(rdSel))
      SEL_RX_CSR: begin
        busRdata[DONE_BIT] = rxDone;
        busRdata[IE_BIT]   = rxIe;
      end
      SEL_RX_BUF: begin
        busRdata[BYTE_W-1:0] = rxData;
        busRdata[RBRK_BIT]   = rxBrk;
        busRdata[OVR_BIT]    = rxOvr;
        busRdata[ERR_BIT]    = rxErr;
      end
      SEL_TX_CSR: begin
        busRdata[DONE_BIT]  = txDone;
        busRdata[IE_BIT]    = txIe;
        busRdata[MAINT_BIT] = txMaint;
        busRdata[BRK_BIT]   = txBrk;
      end
      default: busRdata = '0;
    endcase
  end

  // R4: neither request can stand without its enable
  a_r4_rx_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> rxIe);
  a_r4_tx_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> txIe);

  // R3: a CSR write alone does not move receive done
  a_r3_rx_done_ignores_write: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rxCsrWr && !stb.rxBufRd && !engRxValid) |=> $stable(rxDone));

  // R6: buffer read with no load clears done, errors and request
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rxBufRd && !engRxValid) |=> (!rxDone && !rxErr && !rxIrq));

  // R8: load onto an unread byte flags overrun
  a_r8_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (engRxValid && rxDone && !stb.rxBufRd) |=> (rxOvr && rxErr));

  // R10: transmit write drops done and the request for the handoff cycle
  a_r10_done_low_on_hand: assert property (@(posedge clk) disable iff (!rstN)
    stb.txBufWr |=> (!txDone && !txIrq));

endmodule

// File: rtl/consoleRegIf.sv
module consoleRegIf
  import consoleRegPkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              rxIrq,
  output logic              txIrq,
  input  logic              engRxValid,
  input  logic [BYTE_W-1:0] engRxByte,
  input  logic              engRxBreak,
  output logic              engTxValid,
  output logic [BYTE_W-1:0] engTxByte,
  output logic              engInit
);

  ctlStrobes_t stb;
  logic        txBrkNow;
  logic [DATA_W-1:0] pathRdata;
  logic        addrInRange;

  generate
    if (ADDR_W > 2) begin : g_rdWide
      assign addrInRange = ~|busAddr[ADDR_W-1:2];
    end else begin : g_rdNarrow
      assign addrInRange = 1'b1;
    end
  endgenerate

  assign busRdata = addrInRange ? pathRdata : '0;

  consoleRegCtl #(.ADDR_W(ADDR_W)) i_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWrite   (busWrite),
    .busAddr    (busAddr),
    .wdataBrk   (busWdata[BRK_BIT]),
    .txBrkNow   (txBrkNow),
    .stb        (stb),
    .engTxValid (engTxValid),
    .engInit    (engInit)
  );

  consoleRegPath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rdSel      (busAddr[1:0]),
    .busWdata   (busWdata),
    .engRxValid (engRxValid),
    .engRxByte  (engRxByte),
    .engRxBreak (engRxBreak),
    .busRdata   (pathRdata),
    .rxIrq      (rxIrq),
    .txIrq      (txIrq),
    .txByte     (engTxByte),
    .txBrkNow   (txBrkNow)
  );

  initial begin
    if (DATA_W < MIN_DATA_W) $error("DATA_W too small for the register layout");
  end

endmodule

// File: tb/test_consoleRegIf.sv
module test_consoleRegIf;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWdata = 16'h0;
  logic [15:0] busRdata;
  logic        rxIrq, txIrq;
  logic        engRxValid = 1'b0;
  logic [7:0]  engRxByte = 8'h0;
  logic        engRxBreak = 1'b0;
  logic        engTxValid;
  logic [7:0]  engTxByte;
  logic        engInit;

  int errors = 0;
  int checks = 0;
  bit started = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  consoleRegIf i_consoleRegIf (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxIrq(rxIrq), .txIrq(txIrq), .engRxValid(engRxValid),
    .engRxByte(engRxByte), .engRxBreak(engRxBreak),
    .engTxValid(engTxValid), .engTxByte(engTxByte), .engInit(engInit)
  );

  // behavioural reference state
  bit       mRxIe, mRxDone, mRxBrk, mRxOvr, mRxErr, mRxIrq;
  bit [7:0] mRxData;
  bit       mTxIe, mTxDone = 1'b1, mTxBrk, mTxMaint, mTxIrq;
  bit       mHand, mInit;
  bit [7:0] mHandByte;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [15:0] expRd(bit [1:0] a);
    case (a)
      2'd0:    return {8'h0, mRxDone, mRxIe, 6'h0};
      2'd1:    return {mRxErr, mRxOvr, mRxBrk, 5'h0, mRxData};
      2'd2:    return {8'h0, mTxDone, mTxIe, 3'h0, mTxMaint, 1'b0, mTxBrk};
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit oRxDone, oRxIe, oTxDone, oTxIe, oTxBrk, oHand;
    bit rxCsrW, rxBufR, txCsrW, txBufW;
    started = 1'b1;
    if (!rstN) begin
      {mRxIe, mRxDone, mRxBrk, mRxOvr, mRxErr, mRxIrq} = '0;
      mRxData = 8'h0;
      {mTxIe, mTxBrk, mTxMaint, mTxIrq, mHand, mInit} = '0;
      mTxDone = 1'b1;
      mHandByte = 8'h0;
    end else begin
      oRxDone = mRxDone; oRxIe = mRxIe;
      oTxDone = mTxDone; oTxIe = mTxIe; oTxBrk = mTxBrk; oHand = mHand;
      rxCsrW = busSel && busWrite  && busAddr == 2'd0;
      rxBufR = busSel && !busWrite && busAddr == 2'd1;
      txCsrW = busSel && busWrite  && busAddr == 2'd2;
      txBufW = busSel && busWrite  && busAddr == 2'd3;
      // receive side
      if (rxCsrW) begin
        if (!busWdata[6]) mRxIrq = 1'b0;
        else if (oRxDone && !oRxIe) mRxIrq = 1'b1;
        mRxIe = busWdata[6];
      end
      if (rxBufR) begin
        mRxDone = 1'b0; mRxBrk = 1'b0; mRxOvr = 1'b0; mRxErr = 1'b0; mRxIrq = 1'b0;
      end
      if (engRxValid) begin
        if (oRxDone && !rxBufR) begin mRxOvr = 1'b1; mRxErr = 1'b1; end
        if (engRxBreak) begin mRxBrk = 1'b1; mRxErr = 1'b1; end
        mRxData = engRxByte;
        mRxDone = 1'b1;
        if (mRxIe) mRxIrq = 1'b1;
      end
      // transmit side
      mInit = txCsrW && oTxBrk && !busWdata[0];
      if (txCsrW) begin
        if (!busWdata[6]) mTxIrq = 1'b0;
        else if (oTxDone && !oTxIe) mTxIrq = 1'b1;
        mTxIe = busWdata[6]; mTxBrk = busWdata[0]; mTxMaint = busWdata[2];
      end
      if (oHand) begin
        mTxDone = 1'b1;
        if (mTxIe) mTxIrq = 1'b1;
      end
      mHand = txBufW;
      if (txBufW) begin
        mHandByte = busWdata[7:0];
        mTxDone = 1'b0;
        mTxIrq = 1'b0;
      end
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R2 rdata", busRdata, expRd(busAddr));
      chk("R5 rxIrq", rxIrq, mRxIrq);
      chk("R5 txIrq", txIrq, mTxIrq);
      chk("R10 engTxValid", engTxValid, mHand);
      if (mHand) chk("R10 engTxByte", engTxByte, mHandByte);
      chk("R11 engInit", engInit, mInit);
    end
  end

  task automatic idle();
    @(posedge clk); #2;
    busSel = 1'b0; busWrite = 1'b0; engRxValid = 1'b0; engRxBreak = 1'b0;
  endtask

  task automatic wr(bit [1:0] a, bit [15:0] d);
    @(posedge clk); #2;
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    engRxValid = 1'b0; engRxBreak = 1'b0;
  endtask

  task automatic rd(bit [1:0] a, string tag, int exp);
    @(posedge clk); #2;
    busSel = 1'b1; busWrite = 1'b0; busAddr = a; engRxValid = 1'b0;
    #1 chk(tag, busRdata, exp);
  endtask

  task automatic peek(bit [1:0] a, string tag, int exp);
    busAddr = a;
    #1 chk(tag, busRdata, exp);
  endtask

  task automatic load(bit [7:0] b, bit brk);
    @(posedge clk); #2;
    busSel = 1'b0; engRxValid = 1'b1; engRxByte = b; engRxBreak = brk;
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    idle();
    // R1 reset state
    peek(2'd0, "R1 rx csr", 16'h0000);
    peek(2'd2, "R1 tx csr", 16'h0080);
    peek(2'd1, "R1 rx buf", 16'h0000);
    chk("R1 rxIrq", rxIrq, 0);
    chk("R1 txIrq", txIrq, 0);
    // R2 layout, R5 raise on enable with done set
    wr(2'd2, 16'hFFFF); idle();
    peek(2'd2, "R2 tx csr layout", 16'h00C5);
    peek(2'd3, "R2 tx buf reads zero", 16'h0000);
    chk("R5 tx raise", txIrq, 1);
    chk("R11 no init on set", engInit, 0);
    // R11 break fall
    wr(2'd2, 16'h0044); idle();
    chk("R11 init pulse", engInit, 1);
    idle();
    chk("R11 init one cycle", engInit, 0);
    chk("R5 enable held keeps irq", txIrq, 1);
    peek(2'd2, "R2 tx csr", 16'h00C4);
    // R4 disable clears
    wr(2'd2, 16'h0000); idle();
    chk("R4 tx irq cleared", txIrq, 0);
    peek(2'd2, "R3 tx done kept", 16'h0080);
    // R3 done not writable, R5 no raise with done clear
    wr(2'd0, 16'hFFFF); idle();
    peek(2'd0, "R3 rx done not written", 16'h0040);
    chk("R5 no raise without done", rxIrq, 0);
    wr(2'd0, 16'h0000);
    // R7 load with enable off
    load(8'hA5, 1'b0); idle();
    peek(2'd0, "R7 rx done set", 16'h0080);
    chk("R7 no irq when disabled", rxIrq, 0);
    wr(2'd0, 16'h0040); idle();
    chk("R5 rx raise", rxIrq, 1);
    // R6 read side effects
    rd(2'd1, "R6 rx buf value", 16'h00A5); idle();
    peek(2'd0, "R6 done cleared", 16'h0040);
    chk("R6 irq cleared", rxIrq, 0);
    // R8 overrun
    load(8'h11, 1'b0); load(8'h22, 1'b0); idle();
    chk("R7 irq when enabled", rxIrq, 1);
    peek(2'd1, "R8 overrun flags", 16'hC022);
    rd(2'd1, "R8 read flags", 16'hC022); idle();
    peek(2'd1, "R6 errors cleared", 16'h0022);
    // R9 break
    load(8'h33, 1'b1); idle();
    peek(2'd1, "R9 break flags", 16'hA033);
    // R4 other channel untouched
    wr(2'd2, 16'h0000); idle();
    chk("R4 rx irq untouched", rxIrq, 1);
    rd(2'd1, "R9 read", 16'hA033); idle();
    // R10 transmit handoff
    wr(2'd2, 16'h0040); idle();
    chk("R5 tx raise again", txIrq, 1);
    wr(2'd3, 16'hBEEF); idle();
    chk("R10 hand strobe", engTxValid, 1);
    chk("R10 low byte", engTxByte, 8'hEF);
    chk("R10 irq dropped", txIrq, 0);
    peek(2'd2, "R10 done low", 16'h0040);
    idle();
    chk("R10 strobe ends", engTxValid, 0);
    chk("R10 irq back", txIrq, 1);
    peek(2'd2, "R10 done back", 16'h00C0);
    // enable written during the handoff cycle
    wr(2'd2, 16'h0000); wr(2'd3, 16'h1234); wr(2'd2, 16'h0040); idle();
    chk("R5 enable during handoff", txIrq, 1);
    peek(2'd2, "R10 done after handoff", 16'h00C0);
    // random mix, compared every clock
    for (int i = 0; i < 600; i++) begin
      @(posedge clk); #2;
      busSel = ($urandom_range(0, 2) != 0);
      busWrite = $urandom_range(0, 1);
      busAddr = 2'($urandom_range(0, 3));
      busWdata = 16'($urandom);
      engRxValid = ($urandom_range(0, 3) == 0);
      engRxByte = 8'($urandom);
      engRxBreak = ($urandom_range(0, 7) == 0);
    end
    idle(); idle();
    finishRun();
  end

endmodule